// File: doc/BRIEF.md
# Multi-shape waveform sample generator

This block produces a stream of 8-bit unsigned samples for a low-rate function generator. A rate divisor sets how many clock cycles separate two samples. A 128-step phase counter walks through one waveform period. The shape logic turns each phase into a ramp, triangle or square sample. For square and triangle shapes, a duty selector picks where the high part ends or where the peak sits.

A fourth shape code handles sine. In that mode the block drives the sample word to zero and only supplies the phase index, which an external sine table looks up. Every sample is presented together with its phase index and a one-cycle valid strobe. All outputs are registered.

Top module: `shape_sample_gen`

## Requirements
- R1: A synchronous active-high reset clears the sample word, the phase index and the valid strobe to 0 on the next clock edge, and they stay 0 while reset is held.
- R2: With a rate divisor D of 1 or more, valid pulses are exactly D clock cycles apart. Each pulse lasts one cycle when D is greater than 1.
- R3: A divisor value of 0 behaves like 1, giving one sample on every clock cycle.
- R4: The phase index starts at 0 after reset and rises by one with each valid sample. It wraps from 127 back to 0, so one period is 128 samples.
- R5: Shape code 0 (ramp) outputs twice the phase index, from 0 up to 254.
- R6: Shape code 2 (square) outputs 255 while the phase is below a breakpoint B, and 0 otherwise. The duty code sets B: code 0 (10 %) gives 13, code 1 (30 %) gives 38, code 2 (50 %) gives 64 and code 3 (70 %) gives 90.
- R7: Shape code 1 (triangle) outputs floor(p*255/B) for p <= B and floor((127-p)*255/(127-B)) for p > B. B is the same breakpoint as in R6. The wave is 0 at phase 0, 255 at the breakpoint and 0 at phase 127.
- R8: Shape code 3 (sine) outputs a sample word of 0, while the phase index still advances as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| shape_i | input | 2 | Shape code: 0 ramp, 1 triangle, 2 square, 3 sine |
| duty_i | input | 2 | Duty code: 0=10 %, 1=30 %, 2=50 %, 3=70 % |
| rate_div_i | input | 16 | Clock cycles between samples (0 treated as 1) |
| sample_o | output | 8 | Unsigned sample word |
| phase_o | output | 7 | Phase index that belongs to the current sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench plays full periods and more of each shape, and compares every sample, together with its phase, against values computed from the formulas above.

- The ramp runs past 128 samples at divisor 1, which shows the wrap point.
- The triangle is run with three duty codes, so an off-by-one on a breakpoint or on a slope divisor shows up.
- The square is run with two duty codes at divisors 3 and 0. This separates a wrong threshold from a wrong rate, and checks that divisor 0 gives back-to-back samples.
- A sine run at divisor 4 confirms the sample word stays at zero while the phase moves.

// File: rtl/shape_gen_pkg.sv
package shape_gen_pkg;

  typedef enum logic [1:0] {
    SHP_RAMP   = 2'd0,
    SHP_TRI    = 2'd1,
    SHP_SQUARE = 2'd2,
    SHP_SINE   = 2'd3
  } shape_e;

  localparam int NUM_DUTY = 4;

  // duty code -> percent: 10, 30, 50, 70
  function automatic int duty_pct(input int code);
    return 10 + 20 * code;
  endfunction

  // rounded breakpoint phase for a duty code over 'steps' phases
  function automatic int duty_break(input int code, input int steps);
    return (duty_pct(code) * steps + 50) / 100;
  endfunction

endpackage

// File: rtl/sgen_tick_div.sv
module sgen_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_div;

  always_comb begin
    eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
    tick_o  = (cnt_q >= eff_div - DIV_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  // R2
  cnt_wraps_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> (cnt_q == '0));

  // R3
  zero_div_ticks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_i == '0) |-> tick_o);

endmodule

// File: rtl/sgen_phase_ctr.sv
module sgen_phase_ctr #(
  parameter int PHASE_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               tick_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + PHASE_W'(1);
  end

  assign phase_o = phase_q;

  // R4
  phase_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> (phase_q == $past(phase_q) + PHASE_W'(1)));

  // R4
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/sgen_shape_logic.sv
module sgen_shape_logic
  import shape_gen_pkg::*;
#(
  parameter int PHASE_W  = 7,
  parameter int SAMPLE_W = 8
) (
  input  logic [PHASE_W-1:0]  phase_i,
  input  logic [1:0]          shape_i,
  input  logic [1:0]          duty_i,
  output logic [SAMPLE_W-1:0] sample_o
);

  localparam int STEPS = 1 << PHASE_W;
  localparam int TOP   = STEPS - 1;
  localparam int MAXV  = (1 << SAMPLE_W) - 1;

  logic [SAMPLE_W-1:0] tri_val [NUM_DUTY];
  logic [SAMPLE_W-1:0] sq_val  [NUM_DUTY];
  logic [SAMPLE_W-1:0] ramp_val;
  int                  ph;

  assign ph = int'(phase_i);

  generate
    for (genvar d = 0; d < NUM_DUTY; d++) begin : g_duty
      localparam int BRK  = duty_break(d, STEPS);
      localparam int FALL = TOP - BRK;
      always_comb begin
        if (ph <= BRK) tri_val[d] = SAMPLE_W'((ph * MAXV) / BRK);
        else           tri_val[d] = SAMPLE_W'(((TOP - ph) * MAXV) / FALL);
        sq_val[d] = (ph < BRK) ? SAMPLE_W'(MAXV) : '0;
      end
    end
  endgenerate

  generate
    if (SAMPLE_W > PHASE_W) begin : g_ramp_wide
      assign ramp_val = SAMPLE_W'(phase_i) << (SAMPLE_W - PHASE_W);
    end else begin : g_ramp_narrow
      assign ramp_val = phase_i[PHASE_W-1 -: SAMPLE_W];
    end
  endgenerate

  always_comb begin
    unique case (shape_e'(shape_i))
      SHP_RAMP:   sample_o = ramp_val;
      SHP_TRI:    sample_o = tri_val[duty_i];
      SHP_SQUARE: sample_o = sq_val[duty_i];
      default:    sample_o = '0;
    endcase
  end

endmodule

// File: rtl/shape_sample_gen.sv
module shape_sample_gen
  import shape_gen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PHASE_W  = 7,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [1:0]          shape_i,
  input  logic [1:0]          duty_i,
  input  logic [DIV_W-1:0]    rate_div_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [PHASE_W-1:0]  phase_o,
  output logic                valid_o
);

  localparam int MAXV = (1 << SAMPLE_W) - 1;

  logic                tick;
  logic [PHASE_W-1:0]  phase;
  logic [SAMPLE_W-1:0] shaped;
  logic [SAMPLE_W-1:0] sample_q;
  logic [PHASE_W-1:0]  phase_q;
  logic                valid_q;

  sgen_tick_div #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .div_i  (rate_div_i),
    .tick_o (tick)
  );

  sgen_phase_ctr #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick),
    .phase_o (phase)
  );

  sgen_shape_logic #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_shape (
    .phase_i  (phase),
    .shape_i  (shape_i),
    .duty_i   (duty_i),
    .sample_o (shaped)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sample_q <= '0;
      phase_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= tick;
      if (tick) begin
        sample_q <= shaped;
        phase_q  <= phase;
      end
    end
  end

  assign sample_o = sample_q;
  assign phase_o  = phase_q;
  assign valid_o  = valid_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!valid_o && sample_o == '0 && phase_o == '0));

  // R5
  ramp_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && $past(shape_i) == SHP_RAMP) |-> (sample_o == {phase_o, 1'b0}));

  // R6
  square_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && $past(shape_i) == SHP_SQUARE)
      |-> (sample_o == '0 || sample_o == SAMPLE_W'(MAXV)));

  // R8
  sine_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && $past(shape_i) == SHP_SINE) |-> (sample_o == '0));

endmodule

// File: tb/shape_sample_gen_bench.sv
module shape_sample_gen_bench;

  typedef struct {
    int    sample;
    int    phase;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  shape = 2'd0;
  logic [1:0]  duty = 2'd0;
  logic [15:0] rate_div = 16'd1;
  logic [7:0]  sample;
  logic [6:0]  phase;
  logic        valid;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t expq[$];
  int   exp_gap  = 1;
  int   gap      = 0;
  bit   first    = 1'b1;
  bit   done     = 1'b0;

  always #4 clk = ~clk;

  shape_sample_gen u_shape_sample_gen (
    .clk_i      (clk),
    .rst_i      (rst),
    .shape_i    (shape),
    .duty_i     (duty),
    .rate_div_i (rate_div),
    .sample_o   (sample),
    .phase_o    (phase),
    .valid_o    (valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int brk(input int d);
    return ((10 + 20 * d) * 128 + 50) / 100;
  endfunction

  function automatic exp_t model(input int shp, input int d, input int p);
    exp_t e;
    int b;
    b = brk(d);
    e.phase = p;
    case (shp)
      0: begin e.sample = 2 * p; e.req = "R5"; end
      1: begin
        e.sample = (p <= b) ? (p * 255) / b : ((127 - p) * 255) / (127 - b);
        e.req = "R7";
      end
      2: begin e.sample = (p < b) ? 255 : 0; e.req = "R6"; end
      default: begin e.sample = 0; e.req = "R8"; end
    endcase
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      gap   = 0;
      first = 1'b1;
    end else begin
      gap++;
      if (valid) begin
        if (!first) check("R2/R3 gap", gap, exp_gap);
        first = 1'b0;
        gap   = 0;
        if (expq.size() == 0) begin
          check("R2 unexpected sample", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check({e.req, " sample"}, int'(sample), e.sample);
          check("R4 phase", int'(phase), e.phase);
        end
      end
    end
  end

  task automatic run_case(input int shp, input int d, input int dv, input int n);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    shape    = 2'(shp);
    duty     = 2'(d);
    rate_div = 16'(dv);
    exp_gap  = (dv == 0) ? 1 : dv;
    for (int i = 0; i < n; i++) expq.push_back(model(shp, d, i % 128));
    rst = 1'b0;
    wait (expq.size() == 0);
    @(posedge clk); #1;
    rst = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(valid), 0);
    check("R1 sample", int'(sample), 0);
    check("R1 phase", int'(phase), 0);
    run_case(0, 0, 1, 130);   // R5 ramp with wrap, R4
    run_case(1, 2, 1, 128);   // R7 triangle 50 %
    run_case(1, 0, 2, 128);   // R7 triangle 10 %
    run_case(1, 3, 1, 128);   // R7 triangle 70 %
    run_case(2, 1, 3, 128);   // R6 square 30 %, R2 divisor 3
    run_case(2, 3, 0, 130);   // R6 square 70 %, R3 divisor 0
    run_case(3, 0, 4, 20);    // R8 sine
    // R1 reset held after activity
    @(posedge clk); @(negedge clk);
    check("R1 held valid", int'(valid), 0);
    check("R1 held sample", int'(sample), 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule